// File: doc/BRIEF.md
# Sixteen-Instruction Accumulator Processor Core

This block is a small 8-bit processor built around an accumulator, one general register and a zero flag. It reaches memory through a 16-bit address bus, a read strobe, a write strobe and a split data path: one input byte, one output byte and an output enable. The output enable is the only signal that should turn on the data pad drivers. Internally it holds an address register and a program counter, both 16 bits wide. It also holds three 8-bit scratch registers: a data latch, an opcode register and a holding register for the low half of an address.

A hardwired control unit steps a small state counter through three fetch states and then through the execute states of the current opcode. The counter returns to zero when the instruction ends. The instructions are: a no-op; a load and a store of the accumulator at a direct address; moves in both directions between the accumulator and the general register; an unconditional jump; a jump taken on zero; a jump taken on not-zero; and eight single-cycle ALU operations.

Direct addresses follow the opcode as two bytes, low byte first. The low byte is parked in the holding register until the high byte arrives. A conditional jump that is not taken steps the program counter past both address bytes.

Top module: `acc_cpu16`

## Requirements
- R1: A synchronous reset clears the program counter, accumulator, general register, zero flag and state counter. While reset is held, neither strobe nor the output enable is asserted. After release, the first fetch reads address 0000h.
- R2: Every instruction begins with three fetch states. In the second fetch state the program counter value is on the address bus with the read strobe high, and the program counter then advances by one.
- R3: Opcode 03h copies the accumulator into the general register, and opcode 04h copies the general register into the accumulator. Each takes one execute state, so 4 cycles in total, and neither changes the zero flag.
- R4: Opcode 01h loads the accumulator from the direct address formed from the next two bytes (low byte first). It takes five execute states (8 cycles in total) and leaves the zero flag unchanged.
- R5: Opcode 02h writes the accumulator to the direct address. It takes 8 cycles, and the write strobe is high for exactly one cycle, the last one, with the accumulator value on the data output.
- R6: The data output enable is high in exactly the cycles in which the write strobe is high.
- R7: Opcode 05h loads the program counter with the two address bytes that follow it. It takes 6 cycles.
- R8: Opcode 06h jumps when the zero flag is 1, and opcode 07h jumps when it is 0. A taken jump takes 6 cycles. A jump that is not taken takes 5 cycles and continues at the byte after its two address bytes.
- R9: Opcodes 08h to 0Fh set the accumulator, modulo 256, to: add R, subtract R, increment, clear, AND R, OR R, XOR R, and bitwise invert, in that order. Each takes 4 cycles.
- R10: After any of opcodes 08h to 0Fh, the zero flag is 1 exactly when the new accumulator value is 0 (clear always sets it).
- R11: Opcode 00h and every opcode from 10h to FFh act as a no-op of 4 cycles that leaves the accumulator, the general register and the zero flag unchanged.
- R12: The state counter either increments by one or returns to zero, and it returns to zero only on the last state of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; the byte on data_i is captured at the end of the cycle |
| mem_wr | output | 1 | Write strobe; data_o is written at the end of the cycle |
| data_i | input | 8 | Byte returned by memory for the current address |
| data_o | output | 8 | Byte to be written, driven from the data latch |
| data_oe | output | 1 | Enable for the data pad drivers |

## Verification
Several rules are checked on every clock by the bound checker. These are: the counter stepping rule; the read strobe in the second fetch state; the single-cycle write that carries the accumulator and ends the instruction; the zero flag tracking the accumulator after ALU operations; and the no-op and register-move opcodes leaving the other architectural state alone. Some behaviours can only be shown by the bench's directed programs, watched through the memory writes they produce. These are: the arithmetic results, the low-byte-first address order, the cycle counts of each instruction class, and the choice between taken and fall-through paths for the conditional jumps.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    // Width of the control state counter; the longest routine ends in state 7.
    localparam int STEP_W = 3;
    // Opcode register width.
    localparam int OPC_W  = 8;
    // Number of opcode bits that select the ALU function.
    localparam int ALU_SEL_W = 3;

    typedef logic [STEP_W-1:0] step_t;

    localparam step_t S_FT0 = step_t'(0);
    localparam step_t S_FT1 = step_t'(1);
    localparam step_t S_FT2 = step_t'(2);
    localparam step_t S_EX0 = step_t'(3);
    localparam step_t S_EX1 = step_t'(4);
    localparam step_t S_EX2 = step_t'(5);
    localparam step_t S_EX3 = step_t'(6);
    localparam step_t S_EX4 = step_t'(7);

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0,
        OP_LDA  = 4'h1,
        OP_STA  = 4'h2,
        OP_A2R  = 4'h3,
        OP_R2A  = 4'h4,
        OP_JMP  = 4'h5,
        OP_JZ   = 4'h6,
        OP_JNZ  = 4'h7,
        OP_ADD  = 4'h8,
        OP_SUB  = 4'h9,
        OP_INC  = 4'hA,
        OP_CLR  = 4'hB,
        OP_AND  = 4'hC,
        OP_OR   = 4'hD,
        OP_XOR  = 4'hE,
        OP_INV  = 4'hF
    } op_e;

    // One bit per register transfer the datapath can perform in a state.
    typedef struct packed {
        logic ar_from_pc;
        logic ar_from_adr;
        logic ar_inc;
        logic pc_inc;
        logic pc_from_adr;
        logic dr_from_mem;
        logic dr_from_ac;
        logic ir_load;
        logic tr_load;
        logic r_from_ac;
        logic ac_from_r;
        logic ac_from_dr;
        logic ac_from_alu;
        logic mem_rd;
        logic mem_wr;
        logic seq_clr;
    } ctrl_t;

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [ALU_SEL_W-1:0] sel,
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    output logic [W-1:0]         y,
    output logic                 zero
);

    always_comb begin
        case (sel)
            3'd0:    y = a + b;
            3'd1:    y = a - b;
            3'd2:    y = a + W'(1);
            3'd3:    y = '0;
            3'd4:    y = a & b;
            3'd5:    y = a | b;
            3'd6:    y = a ^ b;
            default: y = ~a;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/cpu_seq.sv
module cpu_seq
    import cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] ir,
    input  logic             zf,
    output ctrl_t            ctrl,
    output step_t            step
);

    step_t step_d, step_q;
    op_e   op;
    logic  jump_go;
    logic  cond_jump;

    // Anything outside the sixteen defined codes decodes as a no-op.
    always_comb begin
        if (ir[OPC_W-1:4] == '0) op = op_e'(ir[3:0]);
        else                     op = OP_NOP;
        cond_jump = (op == OP_JZ) || (op == OP_JNZ);
        jump_go   = (op == OP_JMP) || (op == OP_JZ && zf) || (op == OP_JNZ && !zf);
    end

    always_comb begin
        ctrl = '0;
        case (step_q)
            S_FT0: ctrl.ar_from_pc = 1'b1;
            S_FT1: begin
                ctrl.mem_rd      = 1'b1;
                ctrl.dr_from_mem = 1'b1;
                ctrl.pc_inc      = 1'b1;
            end
            S_FT2: begin
                ctrl.ir_load    = 1'b1;
                ctrl.ar_from_pc = 1'b1;
            end
            default: begin
                case (op)
                    OP_LDA, OP_STA: begin
                        case (step_q)
                            S_EX0: begin
                                ctrl.mem_rd      = 1'b1;
                                ctrl.dr_from_mem = 1'b1;
                                ctrl.pc_inc      = 1'b1;
                                ctrl.ar_inc      = 1'b1;
                            end
                            S_EX1: begin
                                ctrl.tr_load     = 1'b1;
                                ctrl.mem_rd      = 1'b1;
                                ctrl.dr_from_mem = 1'b1;
                                ctrl.pc_inc      = 1'b1;
                            end
                            S_EX2: ctrl.ar_from_adr = 1'b1;
                            S_EX3: begin
                                if (op == OP_LDA) begin
                                    ctrl.mem_rd      = 1'b1;
                                    ctrl.dr_from_mem = 1'b1;
                                end else begin
                                    ctrl.dr_from_ac  = 1'b1;
                                end
                            end
                            default: begin
                                if (op == OP_LDA) ctrl.ac_from_dr = 1'b1;
                                else              ctrl.mem_wr     = 1'b1;
                                ctrl.seq_clr = 1'b1;
                            end
                        endcase
                    end
                    OP_JMP, OP_JZ, OP_JNZ: begin
                        if (jump_go) begin
                            case (step_q)
                                S_EX0: begin
                                    ctrl.mem_rd      = 1'b1;
                                    ctrl.dr_from_mem = 1'b1;
                                    ctrl.ar_inc      = 1'b1;
                                end
                                S_EX1: begin
                                    ctrl.tr_load     = 1'b1;
                                    ctrl.mem_rd      = 1'b1;
                                    ctrl.dr_from_mem = 1'b1;
                                end
                                default: begin
                                    ctrl.pc_from_adr = 1'b1;
                                    ctrl.seq_clr     = 1'b1;
                                end
                            endcase
                        end else if (cond_jump) begin
                            ctrl.pc_inc = 1'b1;
                            if (step_q != S_EX0) ctrl.seq_clr = 1'b1;
                        end else begin
                            ctrl.seq_clr = 1'b1;
                        end
                    end
                    OP_A2R: begin
                        ctrl.r_from_ac = 1'b1;
                        ctrl.seq_clr   = 1'b1;
                    end
                    OP_R2A: begin
                        ctrl.ac_from_r = 1'b1;
                        ctrl.seq_clr   = 1'b1;
                    end
                    OP_NOP: ctrl.seq_clr = 1'b1;
                    default: begin
                        ctrl.ac_from_alu = 1'b1;
                        ctrl.seq_clr     = 1'b1;
                    end
                endcase
            end
        endcase
    end

    always_comb begin
        if (ctrl.seq_clr) step_d = S_FT0;
        else              step_d = step_q + step_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= S_FT0;
        else     step_q <= step_d;
    end

    assign step = step_q;

endmodule

// File: rtl/acc_cpu16.sv
module acc_cpu16
    import cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe
);

    // A direct address is two data bytes joined.
    localparam int JOIN_W = 2 * DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] ar;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] dr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] tr;
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] r;
        logic              z;
    } dp_t;

    dp_t   dp_d, dp_q;
    ctrl_t ctrl;
    step_t seq_step;

    logic [DATA_W-1:0] alu_y;
    logic              alu_zero;
    logic [ADDR_W-1:0] join_adr;

    // Signals brought out by name for the bound checker.
    logic [DATA_W-1:0] ir_w, ac_w, r_w;
    logic              z_w;

    cpu_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .ir   (dp_q.ir[OPC_W-1:0]),
        .zf   (dp_q.z),
        .ctrl (ctrl),
        .step (seq_step)
    );

    cpu_alu #(.W(DATA_W)) u_alu (
        .sel  (dp_q.ir[ALU_SEL_W-1:0]),
        .a    (dp_q.ac),
        .b    (dp_q.r),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign join_adr = ADDR_W'({dp_q.dr, dp_q.tr} & {JOIN_W{1'b1}});

    always_comb begin
        dp_d = dp_q;
        if (ctrl.ar_from_pc)  dp_d.ar = dp_q.pc;
        if (ctrl.ar_from_adr) dp_d.ar = join_adr;
        if (ctrl.ar_inc)      dp_d.ar = dp_q.ar + ADDR_W'(1);
        if (ctrl.pc_inc)      dp_d.pc = dp_q.pc + ADDR_W'(1);
        if (ctrl.pc_from_adr) dp_d.pc = join_adr;
        if (ctrl.dr_from_mem) dp_d.dr = data_i;
        if (ctrl.dr_from_ac)  dp_d.dr = dp_q.ac;
        if (ctrl.ir_load)     dp_d.ir = dp_q.dr;
        if (ctrl.tr_load)     dp_d.tr = dp_q.dr;
        if (ctrl.r_from_ac)   dp_d.r  = dp_q.ac;
        if (ctrl.ac_from_r)   dp_d.ac = dp_q.r;
        if (ctrl.ac_from_dr)  dp_d.ac = dp_q.dr;
        if (ctrl.ac_from_alu) begin
            dp_d.ac = alu_y;
            dp_d.z  = alu_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign mem_addr = dp_q.ar;
    assign mem_rd   = ctrl.mem_rd;
    assign mem_wr   = ctrl.mem_wr;
    assign data_o   = dp_q.dr;
    assign data_oe  = ctrl.mem_wr;

    assign ir_w = dp_q.ir;
    assign ac_w = dp_q.ac;
    assign r_w  = dp_q.r;
    assign z_w  = dp_q.z;

endmodule

// File: rtl/acc_cpu16_chk.sv
module acc_cpu16_chk
    import cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_o,
    input step_t             step,
    input logic [DATA_W-1:0] ir,
    input logic [DATA_W-1:0] ac,
    input logic [DATA_W-1:0] r,
    input logic              z
);

    logic ex_first;
    logic ir_unused;
    assign ex_first  = (step == S_EX0);
    assign ir_unused = (ir == '0) || (ir[DATA_W-1:4] != '0);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (step == S_FT0 && !mem_rd && !mem_wr && !data_oe));

    assert_fetch_read_R2: assert property (@(posedge clk) disable iff (rst)
        (step == S_FT0) |=> (mem_rd && !mem_wr));

    assert_step_rule_R12: assert property (@(posedge clk) disable iff (rst)
        (step != S_FT0) |-> (step == step_t'($past(step) + step_t'(1))));

    assert_move_a2r_R3: assert property (@(posedge clk) disable iff (rst)
        (ex_first && ir == DATA_W'(8'h03)) |=> (r == $past(ac) && $stable(ac) && $stable(z)));

    assert_move_r2a_R3: assert property (@(posedge clk) disable iff (rst)
        (ex_first && ir == DATA_W'(8'h04)) |=> (ac == $past(r) && $stable(r) && $stable(z)));

    assert_write_data_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (data_oe && data_o == ac));

    assert_single_write_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (step == S_FT0 && !mem_wr));

    assert_zero_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (ex_first && ir[DATA_W-1:3] == 5'b00001) |=> (z == (ac == '0)));

    assert_noop_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (ex_first && ir_unused) |=> (step == S_FT0 && $stable(ac) && $stable(r) && $stable(z)));

endmodule

bind acc_cpu16 acc_cpu16_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .data_oe (data_oe),
    .data_o  (data_o),
    .step    (seq_step),
    .ir      (ir_w),
    .ac      (ac_w),
    .r       (r_w),
    .z       (z_w)
);

// File: tb/acc_cpu16_bench.sv
`timescale 1ns/1ps
module acc_cpu16_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, data_oe;
    logic [7:0]  data_i, data_o;

    logic [7:0]  mem [4096];

    int n_chk = 0, n_fail = 0;
    int n_wr, first_wr, oe_bad, pp;
    logic [15:0] wr_addr;

    always #2.5 clk = ~clk;

    assign data_i = mem[mem_addr[11:0]];

    acc_cpu16 u_acc_cpu16 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .data_i(data_i), .data_o(data_o), .data_oe(data_oe)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
        mem[12'h900] = 8'h5C;
        mem[12'h901] = 8'hA7;
        mem[12'h902] = 8'h00;
        pp = 0;
    endtask

    task automatic put(logic [7:0] b);
        mem[pp[11:0]] = b;
        pp++;
    endtask

    task automatic put_a(logic [7:0] op, logic [15:0] a);
        put(op); put(a[7:0]); put(a[15:8]);
    endtask

    task automatic patch(int at, int target);
        mem[at[11:0]]       = target[7:0];
        mem[at[11:0] + 12'd1] = target[15:8];
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Count negedges from reset release; stores are written into the model.
    task automatic run(int ncyc);
        first_wr = -1; n_wr = 0; oe_bad = 0; wr_addr = '0;
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            if (data_oe !== mem_wr) oe_bad++;
            if (mem_wr) begin
                n_wr++;
                if (first_wr < 0) begin
                    first_wr = i;
                    wr_addr  = mem_addr;
                end
                mem[mem_addr[11:0]] = data_o;
            end
        end
    endtask

    task automatic test_reset();
        clear_mem();
        put(8'h00); put(8'h00);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "rd in reset", mem_rd, 0);
        check_eq("R1", "wr in reset", mem_wr, 0);
        check_eq("R1", "oe in reset", data_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "first fetch addr", mem_addr, 16'h0000);
        check_eq("R2", "fetch read strobe", mem_rd, 1);
        @(negedge clk);
        check_eq("R2", "no read in third fetch state", mem_rd, 0);
        repeat (3) @(negedge clk);
        check_eq("R11", "second fetch after 4-cycle no-op", mem_addr, 16'h0001);
        check_eq("R2", "second fetch read strobe", mem_rd, 1);
    endtask

    task automatic test_alu();
        clear_mem();
        put_a(8'h01, 16'h0900); put(8'h03);
        put_a(8'h01, 16'h0901); put(8'h08); put_a(8'h02, 16'h0810);
        put_a(8'h01, 16'h0901); put(8'h09); put_a(8'h02, 16'h0811);
        put_a(8'h01, 16'h0901); put(8'h0C); put_a(8'h02, 16'h0812);
        put_a(8'h01, 16'h0901); put(8'h0D); put_a(8'h02, 16'h0813);
        put(8'h0A); put_a(8'h02, 16'h0814);
        put_a(8'h01, 16'h0901); put(8'h0E); put_a(8'h02, 16'h0815);
        put(8'h0F); put_a(8'h02, 16'h0816);
        put(8'h0B); put(8'h04); put_a(8'h02, 16'h0817);
        put_a(8'h05, pp[15:0]);
        do_reset();
        run(200);
        check_eq("R9",  "add",            mem[12'h810], 8'h03);
        check_eq("R9",  "sub",            mem[12'h811], 8'h4B);
        check_eq("R9",  "and",            mem[12'h812], 8'h04);
        check_eq("R9",  "or",             mem[12'h813], 8'hFF);
        check_eq("R9",  "inc wrap",       mem[12'h814], 8'h00);
        check_eq("R9",  "xor",            mem[12'h815], 8'hFB);
        check_eq("R9",  "invert",         mem[12'h816], 8'h04);
        check_eq("R3",  "R survives clear, moved back", mem[12'h817], 8'h5C);
        check_eq("R6",  "oe matches write", oe_bad, 0);
    endtask

    task automatic test_store_timing();
        clear_mem();
        put(8'h00); put_a(8'h02, 16'h0A37); put_a(8'h05, 16'h0004);
        do_reset();
        run(40);
        check_eq("R5", "store write cycle", first_wr, 11);
        check_eq("R4", "address low byte first", wr_addr, 16'h0A37);
        check_eq("R5", "one write cycle", n_wr, 1);
        check_eq("R1", "accumulator cleared by reset", mem[12'hA37], 8'h00);
        check_eq("R6", "oe matches write", oe_bad, 0);
    endtask

    task automatic test_branches();
        int fix_a, fix_c, fix_d, fix_e, fix_f;
        clear_mem();
        put(8'h0B);
        put(8'h06); fix_a = pp; put(8'h00); put(8'h00);
        put(8'h0A); put_a(8'h02, 16'h0820);
        patch(fix_a, pp);
        put(8'h07); put(8'h00); put(8'h00);
        put(8'h0A); put_a(8'h02, 16'h0821);
        put(8'h07); fix_c = pp; put(8'h00); put(8'h00);
        put_a(8'h02, 16'h0822);
        patch(fix_c, pp);
        put(8'h06); fix_d = pp; put(8'h00); put(8'h00);
        put(8'h0A); put_a(8'h02, 16'h0823);
        put_a(8'h01, 16'h0902);
        put(8'h07); fix_e = pp; put(8'h00); put(8'h00);
        put_a(8'h02, 16'h0824);
        patch(fix_e, pp);
        patch(fix_d, 16'h0000 + fix_d - 1 + 3);
        put(8'h03); put(8'h09);
        put(8'h06); fix_f = pp; put(8'h00); put(8'h00);
        put_a(8'h02, 16'h0825);
        patch(fix_f, pp);
        put(8'h0A); put_a(8'h02, 16'h0826);
        put_a(8'h05, pp[15:0]);
        do_reset();
        run(300);
        check_eq("R8",  "jz taken skips path",       mem[12'h820], 8'hEE);
        check_eq("R8",  "jnz not taken falls through", mem[12'h821], 8'h01);
        check_eq("R8",  "jnz taken skips path",      mem[12'h822], 8'hEE);
        check_eq("R8",  "jz not taken falls through", mem[12'h823], 8'h02);
        check_eq("R4",  "load keeps zero flag",      mem[12'h824], 8'hEE);
        check_eq("R10", "sub to zero sets flag",     mem[12'h825], 8'hEE);
        check_eq("R10", "path after zero jump",      mem[12'h826], 8'h01);
    endtask

    task automatic test_jump_timing();
        clear_mem();
        put_a(8'h05, 16'h0010);
        pp = 16; put_a(8'h02, 16'h0830);
        do_reset(); run(30);
        check_eq("R7", "jump cycles", first_wr, 13);
        check_eq("R7", "jump target", wr_addr, 16'h0830);

        clear_mem();
        put(8'h0B); put_a(8'h07, 16'h0020); put_a(8'h02, 16'h0831);
        do_reset(); run(30);
        check_eq("R8", "not-taken cycles", first_wr, 16);
        check_eq("R8", "not-taken continues", wr_addr, 16'h0831);

        clear_mem();
        put(8'h0B); put_a(8'h06, 16'h0020);
        pp = 32; put_a(8'h02, 16'h0832);
        do_reset(); run(30);
        check_eq("R8", "taken cycles", first_wr, 17);
        check_eq("R8", "taken target", wr_addr, 16'h0832);
    endtask

    task automatic test_unused_ops();
        clear_mem();
        put_a(8'h01, 16'h0901); put(8'hFF); put(8'h10); put_a(8'h02, 16'h0840);
        do_reset(); run(40);
        check_eq("R11", "unused opcodes keep AC", mem[12'h840], 8'hA7);
        check_eq("R11", "unused opcode cycles", first_wr, 23);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_alu();
        test_store_timing();
        test_branches();
        test_jump_timing();
        test_unused_ops();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule